// File: doc/BRIEF.md
# Frame Memory to Display Streamer

This block plays a stored picture out of a synchronous frame memory toward a display-side pixel sink. The memory is 32 bits wide. Each word holds one pixel: colour in the low 24 bits and an unused byte on top. The picture is stored bottom line first. The streamer therefore generates addresses that start at the last stored row and walk back toward row zero, while x runs left to right inside each row. Returned words pass through a pass-through filter stage of configurable latency and are written into a 32-entry FIFO.

A drain controller holds the FIFO contents back until the FIFO fills. It then empties the FIFO to the sink over a valid/ready handshake, and keeps going for as long as data remains. At the end of a frame, a final partial fill is flushed once every outstanding read has landed. A start pulse launches a frame, using the width and height presented with it. A one-cycle done pulse marks the sink's acceptance of the last pixel.

Address issue is throttled by a credit check: FIFO occupancy plus reads still in flight must stay below the FIFO depth. This check is what keeps the FIFO from overflowing, whatever pattern of backpressure the sink applies.

Top module: `fmem_disp_streamer`

## Requirements
- R1: While and after a synchronous active-low reset, `mem_rd_en`, `pix_valid` and `frame_done` are 0.
- R2: The k-th read of a frame of width W and height H (k = y*W + x, x fastest) uses address (H-1-y)*W + x. Exactly W*H reads are issued per frame, one per cycle in which `mem_rd_en` is high.
- R3: The pixels delivered to the sink appear in the read order of R2. Each delivered word equals the stored word with bits 31:24 forced to 0 and bits 23:0 unchanged.
- R4: For a frame of at least 32 pixels, no pixel is presented until the FIFO has filled, so at least 32 reads have been issued before `pix_valid` first rises.
- R5: Once a burst begins, with the sink always ready, at least 32 pixels are accepted on consecutive cycles.
- R6: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and `pix_data` is unchanged in the next cycle.
- R7: Every pixel is delivered exactly once. This includes frames smaller than 32 pixels and frames whose size is not a multiple of 32, whose tail is flushed after the last read returns.
- R8: `frame_done` is high for exactly one cycle per frame: the cycle after the sink accepts the last pixel.
- R9: A start pulse is ignored while a frame is in progress, and also when width or height is 0. Ignored starts cause no reads and no done pulse.
- R10: Read data is taken from `mem_rdata` MEM_LAT cycles (default 2) after the cycle in which `mem_rd_en` was high.
- R11: The FIFO is never written while full, and no pixel is lost under any backpressure pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Frame launch pulse |
| img_width | input | DIM_W | Pixels per row, sampled with the accepted start |
| img_height | input | DIM_W | Rows per frame, sampled with the accepted start |
| mem_addr | output | ADDR_W | Frame memory word address |
| mem_rd_en | output | 1 | Frame memory read enable |
| mem_rdata | input | 32 | Frame memory read data, MEM_LAT cycles after enable |
| pix_data | output | 32 | Output pixel, top byte zero |
| pix_valid | output | 1 | Output pixel valid |
| pix_ready | input | 1 | Sink ready |
| frame_done | output | 1 | One-cycle pulse after the last pixel is accepted |

## Verification
Several internal faults show up at the ports as soon as the affected pixel or address appears:
- A bad row base or column counter shows on `mem_addr` at the first wrong read.
- A misaligned return tag shows as a wrong or shifted colour word in `pix_data`.
- A wrong FIFO pointer shows as a wrong or shifted colour word at the first burst.

Other faults take until the end of a frame to appear:
- A wrong credit count loses pixels under heavy backpressure.
- A drain that starts early shows `pix_valid` before 32 reads have been issued.
- A stuck flush condition or a wrong accepted count leaves the frame without a done pulse, or pulses it at the wrong time.

Frames are therefore run under several sink patterns and sizes around the FIFO depth, and each is compared pixel by pixel against a model of the stored image.

// File: rtl/fsr_pkg.sv
// Shared types and helpers for the frame memory to display streamer.
// Assumes the pixel word is 32 bits with colour in bits 23:0.
package fsr_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Clears the unused top byte and keeps the colour bits.
    function automatic word_t strip_pad(input word_t w);
        return {8'h00, w[23:0]};
    endfunction
endpackage

// File: rtl/fsr_reader.sv
// Address generator and read-return tagger.
// Issues one read per cycle while allowed, walking stored rows from the last
// one back to the first, x ascending in each row. A shift register of valid
// bits follows each read so that returned data, arriving MEM_LAT cycles after
// its enable, is tagged. Assumes ADDR_W >= 2*DIM_W and nonzero dimensions at launch.
module fsr_reader #(
    parameter int ADDR_W  = 20,
    parameter int DIM_W   = 10,
    parameter int MEM_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DIM_W-1:0]  width,
    input  logic [DIM_W-1:0]  height,
    input  logic              may_issue,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic              issue_idle,
    output logic              ret_vld
);
    localparam int PW = 2 * DIM_W;

    logic              active_q;
    logic [DIM_W-1:0]  w_q;
    logic [DIM_W-1:0]  x_q;
    logic [DIM_W-1:0]  rows_left_q;
    logic [ADDR_W-1:0] base_q;
    logic [PW-1:0]     top_row_base;

    assign top_row_base = PW'(height - 1'b1) * PW'(width);
    assign rd_en        = active_q && may_issue;
    assign rd_addr      = base_q + ADDR_W'(x_q);
    assign issue_idle   = !active_q;

    // Walk counters: load on launch, advance on each issued read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            w_q         <= '0;
            x_q         <= '0;
            rows_left_q <= '0;
            base_q      <= '0;
        end else if (launch) begin
            active_q    <= 1'b1;
            w_q         <= width;
            x_q         <= '0;
            rows_left_q <= height;
            base_q      <= ADDR_W'(top_row_base);
        end else if (rd_en) begin
            if (x_q == w_q - 1'b1) begin
                x_q         <= '0;
                base_q      <= base_q - ADDR_W'(w_q);
                rows_left_q <= rows_left_q - 1'b1;
                if (rows_left_q == DIM_W'(1)) begin
                    active_q <= 1'b0;
                end
            end else begin
                x_q <= x_q + 1'b1;
            end
        end
    end

    generate
        if (MEM_LAT == 1) begin : g_lat1
            logic tag_q;
            // Single-stage return tag.
            always_ff @(posedge clk) begin
                if (!rst_n) tag_q <= 1'b0;
                else        tag_q <= rd_en;
            end
            assign ret_vld = tag_q;
        end else begin : g_latn
            logic [MEM_LAT-1:0] tag_q;
            // Multi-stage return tag shift register.
            always_ff @(posedge clk) begin
                if (!rst_n) tag_q <= '0;
                else        tag_q <= {tag_q[MEM_LAT-2:0], rd_en};
            end
            assign ret_vld = tag_q[MEM_LAT-1];
        end
    endgenerate

    AST_ADDR_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (x_q < w_q) && (rows_left_q != '0)); // R2
endmodule

// File: rtl/fsr_filter.sv
// Pass-through filter stage with LAT register stages (LAT = 0 is a wire).
// The top byte is cleared on entry. Only valid bits are reset.
module fsr_filter #(
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  fsr_pkg::word_t in_data,
    output logic          out_vld,
    output fsr_pkg::word_t out_data
);
    import fsr_pkg::*;

    word_t clean;
    assign clean = strip_pad(in_data);

    generate
        if (LAT == 0) begin : g_wire
            assign out_vld  = in_vld;
            assign out_data = clean;
        end else begin : g_pipe
            logic [LAT-1:0] v_q;
            word_t          d_q [LAT];
            // Stage 0 captures the cleaned input.
            always_ff @(posedge clk) begin
                if (!rst_n) v_q[0] <= 1'b0;
                else        v_q[0] <= in_vld;
                d_q[0] <= clean;
            end
            for (genvar s = 1; s < LAT; s++) begin : g_stage
                // Each later stage copies its predecessor.
                always_ff @(posedge clk) begin
                    if (!rst_n) v_q[s] <= 1'b0;
                    else        v_q[s] <= v_q[s-1];
                    d_q[s] <= d_q[s-1];
                end
            end
            assign out_vld  = v_q[LAT-1];
            assign out_data = d_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/fsr_fifo.sv
// Synchronous FIFO with a combinational head output and an occupancy count.
// Assumes DEPTH is a power of two. The caller guarantees no write when full
// and no read when empty.
module fsr_fifo #(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  fsr_pkg::word_t           wr_data,
    input  logic                     rd_en,
    output fsr_pkg::word_t           head,
    output logic                     full,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   count
);
    import fsr_pkg::*;
    localparam int AW = $clog2(DEPTH);

    word_t           mem_q [DEPTH];
    logic [AW-1:0]   wp_q;
    logic [AW-1:0]   rp_q;
    logic [AW:0]     cnt_q;

    assign head  = mem_q[rp_q];
    assign full  = (cnt_q == (AW+1)'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wp_q] <= wr_data;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en) wp_q <= wp_q + 1'b1;
            if (rd_en) rp_q <= rp_q + 1'b1;
            if (wr_en && !rd_en)      cnt_q <= cnt_q + 1'b1;
            else if (rd_en && !wr_en) cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R7
endmodule

// File: rtl/fsr_drain.sv
// Drain controller: waits for the FIFO to fill, or for an end-of-frame flush
// request, then presents the FIFO head to the sink until the FIFO is empty.
module fsr_drain (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_full,
    input  logic fifo_empty,
    input  logic flush_req,
    input  logic sink_ready,
    output logic out_valid,
    output logic pop
);
    logic burst_q;

    assign out_valid = burst_q && !fifo_empty;
    assign pop       = out_valid && sink_ready;

    // Burst state: enter on full or flush, leave once empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
        end else if (!burst_q) begin
            if (fifo_full || flush_req) burst_q <= 1'b1;
        end else if (fifo_empty) begin
            burst_q <= 1'b0;
        end
    end

    AST_BURST_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_q) |-> !fifo_empty); // R4
endmodule

// File: rtl/fmem_disp_streamer.sv
// Top: frame memory to display streamer.
// Launches a frame on an accepted start, issues reads under a credit check
// (FIFO count plus reads in flight below DEPTH), filters returns, buffers them
// in a FIFO, and drains in full-FIFO bursts with an end-of-frame flush.
// Assumes the memory returns data MEM_LAT cycles after each enable cycle.
module fmem_disp_streamer #(
    parameter int ADDR_W     = 20,
    parameter int DIM_W      = 10,
    parameter int FIFO_DEPTH = 32,
    parameter int MEM_LAT    = 2,
    parameter int FILT_LAT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_W-1:0]  img_width,
    input  logic [DIM_W-1:0]  img_height,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       pix_data,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic              frame_done
);
    import fsr_pkg::*;
    localparam int CW = $clog2(FIFO_DEPTH) + 1;
    localparam int PW = 2 * DIM_W;

    logic          busy_q;
    logic          done_q;
    logic [PW-1:0] total_q;
    logic [PW-1:0] accepted_q;
    logic [CW-1:0] inflight_q;
    logic          launch;
    logic          may_issue;
    logic          issue_idle;
    logic          ret_vld;
    logic          filt_vld;
    word_t         filt_data;
    word_t         head;
    logic          f_full;
    logic          f_empty;
    logic [CW-1:0] f_count;
    logic          flush_req;
    logic          pop;
    logic          last_pop;

    assign launch    = start && !busy_q && (img_width != '0) && (img_height != '0);
    assign may_issue = ({1'b0, f_count} + {1'b0, inflight_q}) < (CW+1)'(FIFO_DEPTH);
    assign flush_req = busy_q && issue_idle && (inflight_q == '0) && !f_empty;
    assign last_pop  = pop && (accepted_q == total_q - 1'b1);
    assign pix_data  = head;
    assign frame_done = done_q;

    fsr_reader #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .MEM_LAT(MEM_LAT)) u_reader (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .width(img_width), .height(img_height), .may_issue(may_issue),
        .rd_addr(mem_addr), .rd_en(mem_rd_en), .issue_idle(issue_idle),
        .ret_vld(ret_vld)
    );

    fsr_filter #(.LAT(FILT_LAT)) u_filter (
        .clk(clk), .rst_n(rst_n), .in_vld(ret_vld), .in_data(mem_rdata),
        .out_vld(filt_vld), .out_data(filt_data)
    );

    fsr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(filt_vld), .wr_data(filt_data),
        .rd_en(pop), .head(head), .full(f_full), .empty(f_empty), .count(f_count)
    );

    fsr_drain u_drain (
        .clk(clk), .rst_n(rst_n), .fifo_full(f_full), .fifo_empty(f_empty),
        .flush_req(flush_req), .sink_ready(pix_ready),
        .out_valid(pix_valid), .pop(pop)
    );

    // Frame bookkeeping: busy window, pixel total, accepted count, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            total_q    <= '0;
            accepted_q <= '0;
        end else begin
            done_q <= last_pop;
            if (launch) begin
                busy_q     <= 1'b1;
                total_q    <= PW'(img_width) * PW'(img_height);
                accepted_q <= '0;
            end else begin
                if (pop)      accepted_q <= accepted_q + 1'b1;
                if (last_pop) busy_q     <= 1'b0;
            end
        end
    end

    // Reads issued but not yet written into the FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else if (mem_rd_en && !filt_vld) begin
            inflight_q <= inflight_q + 1'b1;
        end else if (filt_vld && !mem_rd_en) begin
            inflight_q <= inflight_q - 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_data)); // R6
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> pix_data[31:24] == 8'h00); // R3
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start && busy_q && !last_pop |=> total_q == $past(total_q)); // R9
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !mem_rd_en); // R9
endmodule

// File: tb/tb_fmem_disp_streamer.sv
`timescale 1ns/1ps
module tb_fmem_disp_streamer;
    localparam int ADDR_W = 20;
    localparam int DIM_W  = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [DIM_W-1:0]  img_width = '0;
    logic [DIM_W-1:0]  img_height = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd_en;
    logic [31:0]       mem_rdata;
    logic [31:0]       pix_data;
    logic              pix_valid;
    logic              pix_ready = 1'b0;
    logic              frame_done;

    always #10 clk = ~clk;

    fmem_disp_streamer dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_width(img_width), .img_height(img_height),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
        .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
        .frame_done(frame_done)
    );

    // Frame memory model with two cycles of read latency (R10).
    logic [31:0] fmem [1024];
    logic [31:0] q1, q2;
    always @(posedge clk) begin
        if (mem_rd_en) q1 <= fmem[mem_addr[9:0]];
        q2 <= q1;
    end
    assign mem_rdata = q2;

    int n_checks = 0;
    int n_fail = 0;
    int cur_w = 1, cur_h = 1;
    int rd_cnt, addr_err, acc, data_err, pad_err, hold_err;
    int done_cnt, done_acc, reads_at_first, run, max_run;
    int cyc, last_acc_cyc, done_cyc;
    bit first_seen, prev_stall;
    logic [31:0] prev_data;

    function automatic int exp_addr(input int k);
        int y, x;
        y = k / cur_w;
        x = k % cur_w;
        return (cur_h - 1 - y) * cur_w + x;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        rd_cnt = 0; addr_err = 0; acc = 0; data_err = 0; pad_err = 0;
        hold_err = 0; done_cnt = 0; done_acc = -1; reads_at_first = -1;
        run = 0; max_run = 0; first_seen = 0; prev_stall = 0;
        last_acc_cyc = -10; done_cyc = -20;
    endtask

    // Port monitor, sampling at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_rd_en) begin
                if (int'(mem_addr) != exp_addr(rd_cnt)) addr_err++;
                rd_cnt++;
            end
            if (pix_valid && !first_seen) begin
                first_seen = 1;
                reads_at_first = rd_cnt;
            end
            if (prev_stall && (!pix_valid || pix_data != prev_data)) hold_err++;
            if (pix_valid && pix_data[31:24] != 8'h00) pad_err++;
            if (pix_valid && pix_ready) begin
                if (pix_data != (fmem[exp_addr(acc) & 1023] & 32'h00FF_FFFF)) data_err++;
                acc++;
                run++;
                if (run > max_run) max_run = run;
                last_acc_cyc = cyc;
            end else begin
                run = 0;
            end
            if (frame_done) begin
                done_cnt++;
                done_acc = acc;
                done_cyc = cyc;
            end
            prev_stall = pix_valid && !pix_ready;
            prev_data  = pix_data;
        end
    end

    function automatic bit ready_of(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return (c % 3) != 0;
            2: return ((c / 40) % 2) == 1;
            default: return ((c * 37) % 7) < 3;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(mem_rd_en == 0 && pix_valid == 0 && frame_done == 0, "R1 idle in reset",
              {29'd0, mem_rd_en, pix_valid, frame_done}, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        @(negedge clk);
        check(mem_rd_en == 0 && pix_valid == 0 && frame_done == 0, "R1 idle after reset",
              {29'd0, mem_rd_en, pix_valid, frame_done}, 0);
    endtask

    // One frame under a sink pattern; optionally pokes start mid-frame (R9).
    task automatic run_frame(input int w, input int h, input int mode, input bit poke);
        int total, c;
        total = w * h;
        @(posedge clk); #2;
        clear_mon();
        cur_w = w; cur_h = h;
        img_width = DIM_W'(w); img_height = DIM_W'(h); start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        c = 0;
        while (done_cnt == 0 && c < 20000) begin
            pix_ready = ready_of(mode, c);
            if (poke && c == 20) begin
                img_width = 3; img_height = 3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); #2;
            c++;
        end
        pix_ready = 1'b1;
        start = 1'b0;
        repeat (60) @(posedge clk);
        @(negedge clk);
        check(rd_cnt == total, "R2 read count", rd_cnt, total);
        check(addr_err == 0, "R2 address order", addr_err, 0);
        check(data_err == 0, "R3/R10 pixel data and order", data_err, 0);
        check(pad_err == 0, "R3 pad byte zero", pad_err, 0);
        check(acc == total, "R7/R11 pixels delivered", acc, total);
        check(hold_err == 0, "R6 hold under stall", hold_err, 0);
        check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
        check(done_acc == total && done_cyc == last_acc_cyc + 1, "R8 done timing",
              done_cyc - last_acc_cyc, 1);
        if (total >= 32)
            check(reads_at_first >= 32, "R4 no drain before full", reads_at_first, 32);
        if (total >= 32 && mode == 0)
            check(max_run >= 32, "R5 burst continuity", max_run, 32);
        if (poke)
            check(rd_cnt == total && done_cnt == 1, "R9 start ignored while busy", rd_cnt, total);
    endtask

    task automatic t_zero_dim();
        @(posedge clk); #2;
        clear_mon();
        img_width = 0; img_height = 5; start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        img_width = 4; img_height = 0; start = 1'b1;
        @(posedge clk); #2 start = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        check(rd_cnt == 0 && acc == 0, "R9 zero dimension ignored", rd_cnt + acc, 0);
        check(done_cnt == 0, "R9 no done on ignored start", done_cnt, 0);
    endtask

    task automatic t_reset_mid_frame();
        @(posedge clk); #2;
        img_width = 12; img_height = 10; start = 1'b1; pix_ready = 1'b0;
        @(posedge clk); #2 start = 1'b0;
        repeat (50) @(posedge clk);
        do_reset();
        run_frame(9, 7, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++)
            fmem[i] = {8'(i * 7 + 3), 8'(i), 8'(i ^ 60), 8'(255 - i)};
        do_reset();
        run_frame(8, 6, 0, 0);    // 48 pixels, partial tail
        run_frame(10, 10, 1, 0);  // steady throttling
        run_frame(5, 4, 0, 0);    // below FIFO depth: flush only
        run_frame(16, 8, 2, 0);   // exact multiple, long stalls
        run_frame(1, 1, 3, 0);    // single pixel
        run_frame(13, 7, 3, 1);   // irregular sink, start poke
        t_zero_dim();
        t_reset_mid_frame();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual %0d expected %0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule